// File: doc/BRIEF.md
# FIFO Threshold Offset Register Bank

This block stores the two threshold offsets that a deep FIFO's flag logic compares against its fill level. One is the distance from empty at which the almost-empty flag asserts, and the other is the distance from full at which the almost-full flag asserts. Each offset is 14 bits wide, which suits a 16K-word array. Each offset is kept as a low byte and a high part of 6 bits. The block drives both offsets continuously to the flag comparators. The memory, its pointers and the comparators sit outside this block.

The offsets can be programmed in one of two ways, and the choice is captured only while master reset is high. In byte mode, write-enabled write-clock edges fill four registers in a fixed rotation. In serial mode, a 28-bit stream is clocked in one bit per write-clock edge. In either mode the four registers can be read back byte by byte on the read clock. The rotation used for readback is separate from the one used for writes. Strobes reach the bank only while the load-select input is high. The level of load-select during master reset also picks the default value of both offsets.

Top module: `flag_offset_regs`

## Requirements
- R1: While masterRst is high at a write-clock edge, both offsets become 0x07F if loadSel is low or 0x3FF if loadSel is high, and at the next read-clock edge rdData becomes 0.
- R2: The level of serialSel at a write-clock edge during master reset selects the method: 1 means serial, 0 means byte-wise. Changes to serialSel while masterRst is low have no effect.
- R3: In byte mode, each write-clock edge with loadSel and wrEn high loads the next register in the rotation. Slot 0 is the empty-offset bits 7:0, loaded from wrData[7:0]. Slot 1 is the empty-offset bits 13:8, loaded from wrData[5:0]. Slot 2 is the full-offset bits 7:0 and slot 3 is the full-offset bits 13:8, loaded from the same data bits. After slot 3 the rotation returns to slot 0.
- R4: Each read-clock edge with loadSel and rdEn high registers the next slot onto rdData, zero-extended to 9 bits. The read rotation uses the same slot order as writes but has its own position. rdData holds its value at every other edge.
- R5: Readback works the same way whether byte mode or serial mode was selected.
- R6: In serial mode, each write-clock edge with loadSel and serEn high shifts serIn into a 28-bit chain. After 28 shifts, the first bit sits in empty-offset bit 0, bits 14 to 27 of the stream form the full offset with bit 0 first, and the last bit sits in full-offset bit 13.
- R7: While loadSel is low, wrEn, rdEn and serEn leave both offsets and rdData unchanged.
- R8: In byte mode serEn has no effect, and in serial mode wrEn has no effect.
- R9: Master reset returns both the write rotation and the read rotation to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock; programming, master reset sampling |
| rdClk | input | 1 | Read clock; readback |
| masterRst | input | 1 | Master reset, active high, synchronous |
| loadSel | input | 1 | Steers strobes to the bank; picks defaults at reset |
| serialSel | input | 1 | Method select, sampled during reset (1 = serial) |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Byte readback strobe |
| serEn | input | 1 | Serial shift strobe |
| serIn | input | 1 | Serial data bit |
| wrData | input | 9 | Write data bus |
| emptyOffset | output | 14 | Almost-empty threshold offset |
| fullOffset | output | 14 | Almost-full threshold offset |
| rdData | output | 9 | Readback data |

## Verification
A corrupted offset register shows up on emptyOffset or fullOffset at the write-clock edge that caused it. A write or read rotation that has slipped shows up as a byte landing in the wrong half of an offset, or as the wrong byte on rdData, within at most four strobes. A wrongly latched method shows up on the first serEn or wrEn pulse: either the offsets move when they should hold, or they hold when they should move. The bench keeps a behavioural model of the four slots and both rotations, and it compares all three outputs with that model after every clock.

// File: rtl/flag_offset_pkg.sv
package flag_offset_pkg;
  typedef struct packed {
    logic       init;
    logic       initHigh;
    logic       wrByte;
    logic [1:0] wrSlot;
    logic       shiftBit;
    logic       shiftIn;
  } offCtl_t;
endpackage

// File: rtl/offset_prog_ctrl.sv
module offset_prog_ctrl
  import flag_offset_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic    wrClk,
  input  logic    masterRst,
  input  logic    loadSel,
  input  logic    serialSel,
  input  logic    wrEn,
  input  logic    serEn,
  input  logic    serIn,
  output offCtl_t ctl
);
  localparam int PTR_W = $clog2(NUM_SLOTS);

  logic             serialMode;
  logic [PTR_W-1:0] wrPtr;
  logic             byteStrobe;
  logic             shiftStrobe;

  assign byteStrobe  = !masterRst && loadSel && wrEn && !serialMode;
  assign shiftStrobe = !masterRst && loadSel && serEn && serialMode;

  always_ff @(posedge wrClk) begin
    if (masterRst) begin
      serialMode <= serialSel;
      wrPtr      <= '0;
    end else if (byteStrobe) begin
      wrPtr <= (wrPtr == PTR_W'(NUM_SLOTS - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.init     = masterRst;
    ctl.initHigh = loadSel;
    ctl.wrByte   = byteStrobe;
    ctl.wrSlot   = 2'(wrPtr);
    ctl.shiftBit = shiftStrobe;
    ctl.shiftIn  = serIn;
  end
endmodule

// File: rtl/offset_bank.sv
module offset_bank
  import flag_offset_pkg::*;
#(
  parameter int          OFF_W  = 14,
  parameter int          LSB_W  = 8,
  parameter int          DATA_W = 9,
  parameter logic [13:0] DEF_LO = 14'h07F,
  parameter logic [13:0] DEF_HI = 14'h3FF
) (
  input  logic              wrClk,
  input  offCtl_t           ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [OFF_W-1:0]  emptyOffset,
  output logic [OFF_W-1:0]  fullOffset
);
  localparam int MSB_W   = OFF_W - LSB_W;
  localparam int CHAIN_W = 2 * OFF_W;

  logic [OFF_W-1:0]   emptyQ, fullQ;
  logic [CHAIN_W-1:0] chainNext;

  assign chainNext = {ctl.shiftIn, fullQ, emptyQ[OFF_W-1:1]};

  always_ff @(posedge wrClk) begin
    if (ctl.init) begin
      emptyQ <= ctl.initHigh ? OFF_W'(DEF_HI) : OFF_W'(DEF_LO);
      fullQ  <= ctl.initHigh ? OFF_W'(DEF_HI) : OFF_W'(DEF_LO);
    end else if (ctl.wrByte) begin
      case (ctl.wrSlot)
        2'd0:    emptyQ[LSB_W-1:0]     <= wrData[LSB_W-1:0];
        2'd1:    emptyQ[OFF_W-1:LSB_W] <= wrData[MSB_W-1:0];
        2'd2:    fullQ[LSB_W-1:0]      <= wrData[LSB_W-1:0];
        default: fullQ[OFF_W-1:LSB_W]  <= wrData[MSB_W-1:0];
      endcase
    end else if (ctl.shiftBit) begin
      fullQ  <= chainNext[CHAIN_W-1:OFF_W];
      emptyQ <= chainNext[OFF_W-1:0];
    end
  end

  assign emptyOffset = emptyQ;
  assign fullOffset  = fullQ;
endmodule

// File: rtl/offset_readback.sv
module offset_readback #(
  parameter int OFF_W     = 14,
  parameter int LSB_W     = 8,
  parameter int DATA_W    = 9,
  parameter int NUM_SLOTS = 4
) (
  input  logic              rdClk,
  input  logic              masterRst,
  input  logic              loadSel,
  input  logic              rdEn,
  input  logic [OFF_W-1:0]  emptyOffset,
  input  logic [OFF_W-1:0]  fullOffset,
  output logic [DATA_W-1:0] rdData
);
  localparam int PTR_W = $clog2(NUM_SLOTS);
  localparam int MSB_W = OFF_W - LSB_W;

  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] slotVal [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [OFF_W-1:0] src;
    assign src = (s < 2) ? emptyOffset : fullOffset;
    if (s % 2 == 0) begin : g_lo
      assign slotVal[s] = DATA_W'(src[LSB_W-1:0]);
    end else begin : g_hi
      assign slotVal[s] = DATA_W'(src[OFF_W-1:OFF_W-MSB_W]);
    end
  end

  always_ff @(posedge rdClk) begin
    if (masterRst) begin
      rdPtr  <= '0;
      rdData <= '0;
    end else if (loadSel && rdEn) begin
      rdData <= slotVal[rdPtr];
      rdPtr  <= (rdPtr == PTR_W'(NUM_SLOTS - 1)) ? '0 : rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/flag_offset_regs.sv
module flag_offset_regs
  import flag_offset_pkg::*;
#(
  parameter int          OFF_W  = 14,
  parameter int          LSB_W  = 8,
  parameter int          DATA_W = 9,
  parameter logic [13:0] DEF_LO = 14'h07F,
  parameter logic [13:0] DEF_HI = 14'h3FF
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRst,
  input  logic              loadSel,
  input  logic              serialSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              serEn,
  input  logic              serIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [OFF_W-1:0]  emptyOffset,
  output logic [OFF_W-1:0]  fullOffset,
  output logic [DATA_W-1:0] rdData
);
  localparam int NUM_SLOTS = 4;

  offCtl_t ctl;

  offset_prog_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .wrClk(wrClk), .masterRst(masterRst), .loadSel(loadSel), .serialSel(serialSel),
    .wrEn(wrEn), .serEn(serEn), .serIn(serIn), .ctl(ctl)
  );

  offset_bank #(.OFF_W(OFF_W), .LSB_W(LSB_W), .DATA_W(DATA_W),
                .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_bank (
    .wrClk(wrClk), .ctl(ctl), .wrData(wrData),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset)
  );

  offset_readback #(.OFF_W(OFF_W), .LSB_W(LSB_W), .DATA_W(DATA_W),
                    .NUM_SLOTS(NUM_SLOTS)) u_rd (
    .rdClk(rdClk), .masterRst(masterRst), .loadSel(loadSel), .rdEn(rdEn),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset), .rdData(rdData)
  );
endmodule

// File: rtl/flag_offset_regs_chk.sv
module flag_offset_regs_chk #(
  parameter int          OFF_W  = 14,
  parameter int          DATA_W = 9,
  parameter logic [13:0] DEF_LO = 14'h07F,
  parameter logic [13:0] DEF_HI = 14'h3FF
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              masterRst,
  input logic              loadSel,
  input logic              serialSel,
  input logic              wrEn,
  input logic              rdEn,
  input logic              serEn,
  input logic              serIn,
  input logic [OFF_W-1:0]  emptyOffset,
  input logic [OFF_W-1:0]  fullOffset,
  input logic [DATA_W-1:0] rdData
);
  logic modeSeen;
  always_ff @(posedge wrClk) if (masterRst) modeSeen <= serialSel;

  assert_reset_defaults_R1: assert property (@(posedge wrClk)
    masterRst |=> (emptyOffset == ($past(loadSel) ? OFF_W'(DEF_HI) : OFF_W'(DEF_LO))) &&
                  (fullOffset  == ($past(loadSel) ? OFF_W'(DEF_HI) : OFF_W'(DEF_LO))));

  assert_idle_hold_R7: assert property (@(posedge wrClk) disable iff (masterRst)
    !loadSel |=> $stable(emptyOffset) && $stable(fullOffset));

  assert_rd_hold_R4: assert property (@(posedge rdClk) disable iff (masterRst)
    !(loadSel && rdEn) |=> $stable(rdData));

  assert_serial_ignores_wr_R8: assert property (@(posedge wrClk) disable iff (masterRst)
    (modeSeen && loadSel && !serEn) |=> $stable(emptyOffset) && $stable(fullOffset));

  assert_byte_ignores_ser_R8: assert property (@(posedge wrClk) disable iff (masterRst)
    (!modeSeen && loadSel && !wrEn) |=> $stable(emptyOffset) && $stable(fullOffset));

  assert_shift_step_R6: assert property (@(posedge wrClk) disable iff (masterRst)
    (modeSeen && loadSel && serEn) |=>
      (fullOffset[OFF_W-1] == $past(serIn)) && (emptyOffset[OFF_W-1] == $past(fullOffset[0])));
endmodule

bind flag_offset_regs flag_offset_regs_chk #(
  .OFF_W(OFF_W), .DATA_W(DATA_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .loadSel(loadSel),
  .serialSel(serialSel), .wrEn(wrEn), .rdEn(rdEn), .serEn(serEn), .serIn(serIn),
  .emptyOffset(emptyOffset), .fullOffset(fullOffset), .rdData(rdData)
);

// File: tb/test_flag_offset_regs.sv
`timescale 1ns/1ps
module test_flag_offset_regs;
  logic       clk = 1'b0;
  logic       masterRst = 1'b1, loadSel = 1'b0, serialSel = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, serEn = 1'b0, serIn = 1'b0;
  logic [8:0] wrData = '0;
  logic [13:0] emptyOffset, fullOffset;
  logic [8:0]  rdData;

  always #10 clk = ~clk;

  flag_offset_regs i_flag_offset_regs (
    .wrClk(clk), .rdClk(clk), .masterRst(masterRst), .loadSel(loadSel),
    .serialSel(serialSel), .wrEn(wrEn), .rdEn(rdEn), .serEn(serEn), .serIn(serIn),
    .wrData(wrData), .emptyOffset(emptyOffset), .fullOffset(fullOffset), .rdData(rdData)
  );

  int    checks = 0, failures = 0;
  string curReq = "R1";

  // behavioural reference: four slots, two rotation positions, one mode bit
  int mSlot[4];
  int mWp = 0, mRp = 0, mRd = 0;
  bit mSerial = 0, mValid = 0;

  function automatic int slotMask(int k);
    return (k % 2 == 0) ? 'hFF : 'h3F;
  endfunction
  function automatic int mEmpty();
    return (mSlot[1] << 8) | mSlot[0];
  endfunction
  function automatic int mFull();
    return (mSlot[3] << 8) | mSlot[2];
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (masterRst) begin
      int d;
      d = loadSel ? 'h3FF : 'h07F;
      mSerial = serialSel;
      mSlot[0] = d & 'hFF; mSlot[1] = d >> 8;
      mSlot[2] = d & 'hFF; mSlot[3] = d >> 8;
      mWp = 0; mRp = 0; mRd = 0;
      mValid = 1;
    end else if (loadSel) begin
      if (rdEn) begin
        mRd = mSlot[mRp];
        mRp = (mRp + 1) % 4;
      end
      if (!mSerial && wrEn) begin
        mSlot[mWp] = int'(wrData) & slotMask(mWp);
        mWp = (mWp + 1) % 4;
      end
      if (mSerial && serEn) begin
        longint stream;
        stream = (longint'(mFull()) << 14) | longint'(mEmpty());
        stream = (stream >> 1) | (longint'(serIn) << 27);
        mSlot[0] = int'(stream & 'hFF);
        mSlot[1] = int'((stream >> 8) & 'h3F);
        mSlot[2] = int'((stream >> 14) & 'hFF);
        mSlot[3] = int'((stream >> 22) & 'h3F);
      end
    end
  end

  always @(negedge clk) begin
    if (mValid) begin
      check(curReq, int'(emptyOffset), mEmpty(), "model emptyOffset");
      check(curReq, int'(fullOffset),  mFull(),  "model fullOffset");
      check(curReq, int'(rdData),      mRd,      "model rdData");
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic idle();
    wrEn = 0; rdEn = 0; serEn = 0;
  endtask

  task automatic doReset(bit ls, bit ss);
    idle(); masterRst = 1; loadSel = ls; serialSel = ss;
    tick(2);
    masterRst = 0;
  endtask

  task automatic wrByte(int v);
    wrEn = 1; wrData = 9'(v); tick(); wrEn = 0;
  endtask

  task automatic rdByte(int exp, string req);
    rdEn = 1; tick(); rdEn = 0;
    check(req, int'(rdData), exp, "readback byte");
  endtask

  initial begin
    #(200000 * 20);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 defaults with loadSel low, byte mode
    curReq = "R1";
    doReset(1'b0, 1'b0);
    tick();
    check("R1", int'(emptyOffset), 'h07F, "default empty, loadSel low");
    check("R1", int'(fullOffset),  'h07F, "default full, loadSel low");
    check("R1", int'(rdData),      0,     "rdData after reset");

    // R3 byte writes in slot order with wrap
    curReq = "R3";
    loadSel = 1;
    wrByte('h1AB); wrByte('h1C5); wrByte('h012); wrByte('h03E);
    check("R3", int'(emptyOffset), 'h05AB, "empty after four writes");
    check("R3", int'(fullOffset),  'h3E12, "full after four writes");
    wrByte('h0CD);
    check("R3", int'(emptyOffset), 'h05CD, "wrap to empty low byte");

    // R4 readback rotation with wrap
    curReq = "R4";
    rdByte('hCD, "R4"); rdByte('h05, "R4"); rdByte('h12, "R4");
    rdByte('h3E, "R4"); rdByte('hCD, "R4");
    tick(2);
    check("R4", int'(rdData), 'hCD, "rdData holds without rdEn");

    // R4 independent pointers: write and read on the same edge
    wrEn = 1; rdEn = 1; wrData = 9'h077; tick(); idle();
    check("R4", int'(rdData), 'h05, "read slot 1 while writing slot 1");
    check("R4", int'(emptyOffset), 'h37CD, "write slot 1 same edge");

    // R7 loadSel low: strobes ignored
    curReq = "R7";
    loadSel = 0; wrEn = 1; rdEn = 1; serEn = 1; wrData = 9'h1FF; tick(3); idle();
    check("R7", int'(emptyOffset), 'h37CD, "empty held with loadSel low");
    check("R7", int'(fullOffset),  'h3E12, "full held with loadSel low");
    check("R7", int'(rdData),      'h05,   "rdData held with loadSel low");

    // R8 / R2 byte mode ignores serEn even after serialSel flips
    curReq = "R8";
    serialSel = 1; loadSel = 1; serEn = 1; serIn = 1; tick(4); idle();
    check("R8", int'(emptyOffset), 'h37CD, "serEn ignored in byte mode");
    check("R2", int'(fullOffset),  'h3E12, "serialSel change after reset ignored");

    // R9 reset returns both rotations to slot 0
    curReq = "R9";
    doReset(1'b0, 1'b0);
    loadSel = 1;
    wrByte('h011);
    check("R9", int'(emptyOffset), 'h0011, "write rotation restarts at slot 0");
    rdByte('h11, "R9");

    // R1 defaults with loadSel high, serial mode
    curReq = "R1";
    doReset(1'b1, 1'b1);
    tick();
    check("R1", int'(emptyOffset), 'h3FF, "default empty, loadSel high");
    check("R1", int'(fullOffset),  'h3FF, "default full, loadSel high");

    // R6 serial stream (R2: serialSel dropped after reset)
    curReq = "R6";
    serialSel = 0;
    for (int i = 0; i < 28; i++) begin
      serEn = 1;
      serIn = (i < 14) ? ((14'h1A5C >> i) & 1) : ((14'h2B37 >> (i - 14)) & 1);
      tick();
    end
    idle();
    check("R6", int'(emptyOffset), 'h1A5C, "serial empty offset");
    check("R6", int'(fullOffset),  'h2B37, "serial full offset");
    check("R2", int'(fullOffset),  'h2B37, "serial mode kept after serialSel drop");

    // R8 serial mode ignores wrEn
    curReq = "R8";
    wrByte('h1FF); wrByte('h000);
    check("R8", int'(emptyOffset), 'h1A5C, "wrEn ignored in serial mode");

    // R5 readback in serial mode
    curReq = "R5";
    rdByte('h5C, "R5"); rdByte('h1A, "R5"); rdByte('h37, "R5"); rdByte('h2B, "R5");

    tick(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule